// File: doc/BRIEF.md
# Analog Over-Value Threshold Monitor

This block watches a stream of digitized analog samples, one channel at a time. Each sample arrives with a channel index and a valid strobe. The block compares the sample against that channel's own signed window, which has an upper and a lower limit. A sample outside the window on an enabled channel does three things: it raises a registered trip line towards the central fault manager, it sets a sticky fault bit for that channel, and it marks the channel as currently over its limit.

Sticky fault bits are never cleared automatically. Software clears all of them at once with an acknowledge strobe. The strobe is refused while any enabled channel is still over its limit, so operation cannot resume before the root cause has gone away. The trip line follows the sticky bits: it stays high while any bit is set.

Top module: `ovl_monitor`

## Requirements
- R1: A valid sample on enabled channel c is a violation when, compared as signed two's complement, it is strictly greater than c's high limit or strictly less than c's low limit. A violation sets `over_now[c]` and `fault_latched[c]` at the first clock edge after the sample is presented.
- R2: `trip` is registered. It rises at the edge that accepts a violating sample, so it is visible one clock after the sample, and it is high exactly while any `fault_latched` bit is set.
- R3: A set `fault_latched` bit stays set until an accepted acknowledge. In-range samples and a cleared enable do not clear it.
- R4: An acknowledge is refused, leaving `fault_latched` unchanged, when any enabled channel's `over_now` bit will still be set after that edge. This includes the case where the sample presented in the same cycle is itself a violation.
- R5: An accepted acknowledge clears every `fault_latched` bit at that edge, and `trip` falls with them.
- R6: A channel whose `chan_en` bit is 0 never trips, and its `over_now` bit is held at 0 while it is disabled.
- R7: `over_now[c]` is rewritten by every valid sample for channel c: set on a violation, cleared on an in-range sample. Samples for other channels leave it unchanged.
- R8: A sample whose channel index is NUM_CH or above (6 and 7 with the defaults) is ignored and changes no output.
- R9: After reset, `trip`, `fault_latched` and `over_now` are all 0.
- R10: A sample exactly equal to either limit is in range and does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHAN_W (3) | Channel index of the sample |
| smp_data | input | SAMPLE_W (16) | Signed sample value |
| lim_hi_flat | input | NUM_CH*SAMPLE_W | High limits; channel i occupies bits [i*SAMPLE_W +: SAMPLE_W] |
| lim_lo_flat | input | NUM_CH*SAMPLE_W | Low limits; same packing |
| chan_en | input | NUM_CH (6) | Per-channel enable, 1 = monitored |
| ack | input | 1 | Acknowledge strobe |
| trip | output | 1 | Combined trip towards the fault manager |
| fault_latched | output | NUM_CH | Sticky per-channel fault bits |
| over_now | output | NUM_CH | Per-channel current over-limit status |

## Verification
The bound checker tests relations that must hold on every cycle. `trip` must equal the OR of the sticky bits. No channel may show `over_now` without its sticky bit. A disabled channel must never show `over_now`. Sticky bits must persist unless an acknowledge was applied, and an acknowledge must be refused or accepted according to the over-limit status. The exact signed comparison at the window edges, the once-per-sample update of status for only the addressed channel, and the dropping of out-of-range indices can only be shown by the bench. It does this with directed edge values and a reference model driven by seeded random traffic.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int unsigned OVL_DEF_CH = 6;
    localparam int unsigned OVL_DEF_W  = 16;

    typedef enum logic [1:0] {
        OVL_IN_WINDOW = 2'd0,
        OVL_ABOVE     = 2'd1,
        OVL_BELOW     = 2'd2
    } verdict_e;
endpackage

// File: rtl/ovl_limit_cmp.sv
module ovl_limit_cmp #(
    parameter int unsigned SAMPLE_W = ovl_pkg::OVL_DEF_W
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [SAMPLE_W-1:0] lim_hi,
    input  logic signed [SAMPLE_W-1:0] lim_lo,
    input  logic                       addressed,
    input  logic                       enable,
    output ovl_pkg::verdict_e          verdict,
    output logic                       hit,
    output logic                       viol
);
    always_comb begin
        if (sample > lim_hi) begin
            verdict = ovl_pkg::OVL_ABOVE;
        end else if (sample < lim_lo) begin
            verdict = ovl_pkg::OVL_BELOW;
        end else begin
            verdict = ovl_pkg::OVL_IN_WINDOW;
        end
        hit  = addressed && enable;
        viol = hit && (verdict != ovl_pkg::OVL_IN_WINDOW);
    end
endmodule

// File: rtl/ovl_state.sv
module ovl_state #(
    parameter int unsigned NUM_CH = ovl_pkg::OVL_DEF_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] viol,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic              ack,
    output logic              trip,
    output logic [NUM_CH-1:0] fault,
    output logic [NUM_CH-1:0] over
);
    typedef struct packed {
        logic              trip;
        logic [NUM_CH-1:0] fault;
        logic [NUM_CH-1:0] over;
    } state_t;

    state_t st_q;
    state_t st_d;
    logic   ack_ok;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!chan_en[i]) begin
                st_d.over[i] = 1'b0;
            end else if (hit[i]) begin
                st_d.over[i] = viol[i];
            end
        end
        ack_ok = ack && (st_d.over == '0);
        if (ack_ok) begin
            st_d.fault = '0;
        end else begin
            st_d.fault = st_q.fault | viol;
        end
        st_d.trip = |st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip  = st_q.trip;
    assign fault = st_q.fault;
    assign over  = st_q.over;
endmodule

// File: rtl/ovl_monitor.sv
module ovl_monitor #(
    parameter int unsigned NUM_CH   = ovl_pkg::OVL_DEF_CH,
    parameter int unsigned SAMPLE_W = ovl_pkg::OVL_DEF_W,
    parameter int unsigned CHAN_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [CHAN_W-1:0]          smp_chan,
    input  logic [SAMPLE_W-1:0]        smp_data,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_hi_flat,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_lo_flat,
    input  logic [NUM_CH-1:0]          chan_en,
    input  logic                       ack,
    output logic                       trip,
    output logic [NUM_CH-1:0]          fault_latched,
    output logic [NUM_CH-1:0]          over_now
);
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] viol;
    ovl_pkg::verdict_e verdict [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic addressed;
        assign addressed = smp_valid && (smp_chan == CHAN_W'(g));

        ovl_limit_cmp #(.SAMPLE_W(SAMPLE_W)) cmp_i (
            .sample    ($signed(smp_data)),
            .lim_hi    ($signed(lim_hi_flat[g*SAMPLE_W +: SAMPLE_W])),
            .lim_lo    ($signed(lim_lo_flat[g*SAMPLE_W +: SAMPLE_W])),
            .addressed (addressed),
            .enable    (chan_en[g]),
            .verdict   (verdict[g]),
            .hit       (hit[g]),
            .viol      (viol[g])
        );
    end

    ovl_state #(.NUM_CH(NUM_CH)) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .viol    (viol),
        .chan_en (chan_en),
        .ack     (ack),
        .trip    (trip),
        .fault   (fault_latched),
        .over    (over_now)
    );
endmodule

// File: rtl/ovl_monitor_chk.sv
module ovl_monitor_chk #(
    parameter int unsigned NUM_CH = ovl_pkg::OVL_DEF_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [NUM_CH-1:0] chan_en,
    input logic              ack,
    input logic              trip,
    input logic [NUM_CH-1:0] fault_latched,
    input logic [NUM_CH-1:0] over_now
);
    // R2: the trip line mirrors the sticky bits
    p_trip_mirrors_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trip == (|fault_latched));

    // R1: a channel shown over its limit has its sticky bit set
    p_over_has_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (over_now & ~fault_latched) == '0);

    // R6: a channel disabled in the previous cycle shows no over status
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((over_now & ~$past(chan_en)) == '0));

    // R3: without acknowledge, no sticky bit is lost
    p_latch_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((fault_latched & $past(fault_latched)) == $past(fault_latched)));

    // R4: an acknowledge is refused while an enabled channel stays over
    p_ack_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ((over_now & chan_en) != '0) && (fault_latched != '0) && !smp_valid)
        |=> (fault_latched != '0));

    // R5: an acknowledge with nothing over clears every sticky bit
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ((over_now & chan_en) == '0) && !smp_valid)
        |=> (fault_latched == '0) && !trip);
endmodule

bind ovl_monitor ovl_monitor_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .chan_en       (chan_en),
    .ack           (ack),
    .trip          (trip),
    .fault_latched (fault_latched),
    .over_now      (over_now)
);

// File: tb/ovl_monitor_tb_top.sv
module ovl_monitor_tb_top;
    localparam int unsigned NCH     = 6;
    localparam int unsigned SW      = 16;
    localparam int unsigned CW      = 3;
    localparam time         CLK_PER = 10ns;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  smp_valid = 1'b0;
    logic [CW-1:0]         smp_chan = '0;
    logic [SW-1:0]         smp_data = '0;
    logic [NCH*SW-1:0]     lim_hi_flat;
    logic [NCH*SW-1:0]     lim_lo_flat;
    logic [NCH-1:0]        chan_en = '0;
    logic                  ack = 1'b0;
    logic                  trip;
    logic [NCH-1:0]        fault_latched;
    logic [NCH-1:0]        over_now;

    logic signed [SW-1:0]  hi_m [NCH];
    logic signed [SW-1:0]  lo_m [NCH];
    logic [NCH-1:0]        m_fault = '0;
    logic [NCH-1:0]        m_over = '0;
    int                    n_chk = 0;
    int                    n_bad = 0;
    bit                    done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            lim_hi_flat[i*SW +: SW] = hi_m[i];
            lim_lo_flat[i*SW +: SW] = lo_m[i];
        end
    end

    ovl_monitor #(.NUM_CH(NCH), .SAMPLE_W(SW), .CHAN_W(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .smp_chan      (smp_chan),
        .smp_data      (smp_data),
        .lim_hi_flat   (lim_hi_flat),
        .lim_lo_flat   (lim_lo_flat),
        .chan_en       (chan_en),
        .ack           (ack),
        .trip          (trip),
        .fault_latched (fault_latched),
        .over_now      (over_now)
    );

    function automatic logic is_viol(logic v, logic [CW-1:0] ch, logic signed [SW-1:0] d,
                                     logic [NCH-1:0] en);
        if (!v || ch >= CW'(NCH)) return 1'b0;
        if (!en[ch]) return 1'b0;
        return (d > hi_m[ch]) || (d < lo_m[ch]);
    endfunction

    task automatic check_vec(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check_vec(tag, {{(NCH-1){1'b0}}, trip}, {{(NCH-1){1'b0}}, |m_fault}, "trip");
        check_vec(tag, fault_latched, m_fault, "fault_latched");
        check_vec(tag, over_now, m_over, "over_now");
    endtask

    // drive at negedge, model update for the coming posedge, compare at next negedge
    task automatic step(string tag, logic v, logic [CW-1:0] ch, logic signed [SW-1:0] d, logic a);
        logic viol;
        logic [NCH-1:0] nov;
        smp_valid = v; smp_chan = ch; smp_data = d; ack = a;
        viol = is_viol(v, ch, d, chan_en);
        nov = m_over;
        for (int i = 0; i < NCH; i++) begin
            if (!chan_en[i]) nov[i] = 1'b0;
            else if (v && ch == CW'(i)) nov[i] = viol;
        end
        @(posedge clk);
        m_over = nov;
        if (a && nov == '0) m_fault = '0;
        else if (viol) m_fault = m_fault | (NCH'(1) << ch);
        @(negedge clk);
        smp_valid = 1'b0; ack = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20250;
        void'($urandom(seed));
        for (int i = 0; i < NCH; i++) begin
            hi_m[i] = 16'sd100;
            lo_m[i] = -16'sd100;
        end
        chan_en = '1;
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release");

        step("R10 equal high", 1'b1, 3'd2, 16'sd100, 1'b0);
        step("R10 equal low", 1'b1, 3'd2, -16'sd100, 1'b0);
        step("R1 R2 above high", 1'b1, 3'd2, 16'sd101, 1'b0);
        step("R1 below low", 1'b1, 3'd4, -16'sd101, 1'b0);
        step("R4 ack while over", 1'b0, 3'd0, 16'sd0, 1'b1);
        step("R7 in range clears over ch2", 1'b1, 3'd2, 16'sd5, 1'b0);
        step("R7 other channel untouched", 1'b1, 3'd1, 16'sd7, 1'b0);
        step("R3 still latched", 1'b0, 3'd0, 16'sd0, 1'b0);
        step("R7 in range clears over ch4", 1'b1, 3'd4, -16'sd3, 1'b0);
        step("R4 ack with same-cycle violation", 1'b1, 3'd0, 16'sd300, 1'b1);
        step("R7 clear ch0", 1'b1, 3'd0, 16'sd0, 1'b0);
        step("R5 ack accepted", 1'b0, 3'd0, 16'sd0, 1'b1);
        chan_en[3] = 1'b0;
        step("R6 disabled channel", 1'b1, 3'd3, 16'sd30000, 1'b0);
        step("R8 index out of range", 1'b1, 3'd7, 16'sd30000, 1'b0);
        step("R8 index six", 1'b1, 3'd6, -16'sd30000, 1'b0);
        chan_en[3] = 1'b1;
        step("R1 re-enabled ch3", 1'b1, 3'd3, -16'sd32768, 1'b0);
        chan_en[3] = 1'b0;
        step("R6 disable drops over, R3 keeps latch", 1'b0, 3'd0, 16'sd0, 1'b0);
        step("R5 ack after disable", 1'b0, 3'd0, 16'sd0, 1'b1);
        chan_en = '1;

        for (int i = 0; i < NCH; i++) begin
            hi_m[i] = SW'(($urandom % 2000) + 1);
            lo_m[i] = -SW'(($urandom % 2000) + 1);
        end
        for (int n = 0; n < 4000; n++) begin
            logic v;
            logic a;
            if (($urandom % 64) == 0) chan_en = NCH'($urandom) | NCH'(6'b100001);
            v = ($urandom % 4) != 0;
            a = ($urandom % 8) == 0;
            step("random R1 R3 R4 R5 R6 R7", v, CW'($urandom), SW'(($urandom % 6000) - 3000), a);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule